// File: doc/BRIEF.md
# Capture Mode Sequencer

This block steps a capture memory through its operating phases: initialisation, waiting for a host command, filling memory with samples, an optional pause, and draining memory back out. It waits in the initialisation phase until the memory interface reports that calibration is complete and the sample input FIFO has drained. Only then does it open the command window. From that window it starts a write-only run, a read-only run, or a write-then-read run.

The surrounding write engine, read engine and address logic take their enables and one-cycle parameter-load strobes from this block. They report completion back through two done inputs. A write-then-read run passes through a fixed-length pause between the two phases, and the read parameters are loaded at the start of that pause. A command is taken only while the command window is open. A command carrying the unused mode code is dropped and leaves the machine waiting for a command.

Top module: `capture_seq_ctrl`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) puts the machine in IDLE (state code 0) from any state. After that edge `init_o` is 1; `wr_en_o`, `rd_en_o`, `cmd_ready_o`, `wr_load_o` and `rd_load_o` are 0; and `cfg_param_o` is 0.
- R2: From IDLE the machine moves to CMD (code 1) at the next edge only when `calib_done_i` and `in_fifo_empty_i` are both 1. Otherwise it stays in IDLE.
- R3: `cmd_valid_i` is acted on only in CMD. In any other state it changes neither the state, nor `cfg_param_o`, nor `wr_load_o`.
- R4: In CMD, a valid command with mode 2'b01 (write-only) or 2'b11 (write-then-read) moves to WRITE (code 2) at the next edge. On that edge `wr_load_o` pulses for one cycle and `cfg_param_o` takes `cmd_param_i`.
- R5: In CMD, a valid command with mode 2'b10 (read-only) moves to READ (code 3) at the next edge. On that edge `rd_load_o` pulses for one cycle and `cfg_param_o` takes `cmd_param_i`.
- R6: In CMD, a valid command with mode 2'b00 is ignored. The machine stays in CMD, no load strobe is raised, and `cfg_param_o` is unchanged.
- R7: In WRITE of a write-only run, `wr_done_i` returns the machine to CMD at the next edge.
- R8: In WRITE of a write-then-read run, `wr_done_i` moves the machine to DELAY (code 4) at the next edge, and `rd_load_o` pulses in the first DELAY cycle.
- R9: DELAY lasts exactly DELAY_CYC clock cycles, after which the machine is in READ.
- R10: In READ, `rd_done_i` returns the machine to CMD at the next edge.
- R11: `wr_en_o` is 1 exactly while in WRITE, `rd_en_o` exactly while in READ, `cmd_ready_o` exactly while in CMD, and `init_o` exactly while in IDLE.
- R12: `wr_done_i` outside WRITE and `rd_done_i` outside READ have no effect on the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| calib_done_i | input | 1 | Memory interface calibration finished |
| in_fifo_empty_i | input | 1 | Sample input FIFO is empty |
| cmd_valid_i | input | 1 | Command strobe from the host decoder |
| cmd_mode_i | input | 2 | Mode code: 01 write-only, 10 read-only, 11 write-then-read, 00 unused |
| cmd_param_i | input | PARAM_W | Parameter word carried with the command |
| wr_done_i | input | 1 | Write engine finished its run |
| rd_done_i | input | 1 | Read engine finished its run |
| state_o | output | 3 | Current state: 0 IDLE, 1 CMD, 2 WRITE, 3 READ, 4 DELAY |
| wr_en_o | output | 1 | Write engine enable |
| rd_en_o | output | 1 | Read engine enable |
| cmd_ready_o | output | 1 | Command window open |
| init_o | output | 1 | Clear addresses and command registers (IDLE) |
| wr_load_o | output | 1 | One-cycle strobe: load write parameters |
| rd_load_o | output | 1 | One-cycle strobe: load read parameters |
| cfg_param_o | output | PARAM_W | Parameter word of the last accepted command |

## Verification
The state and every output are registered from the same next-state value, so each result is due one clock edge after the input that causes it. The exception is the pause, which ends DELAY_CYC edges after it is entered. The bench drives inputs on the falling edge, lets one rising edge pass and samples one nanosecond later, so each check looks at exactly the cycle the requirement names. The table vectors step through the pause one edge at a time, so the DELAY-to-READ change is checked at the edge where it must occur and at none before it.

// File: rtl/capture_seq_pkg.sv
package capture_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CMD   = 3'd1,
    ST_WRITE = 3'd2,
    ST_READ  = 3'd3,
    ST_DELAY = 3'd4
  } seq_state_t;

  typedef enum logic [1:0] {
    MD_NONE  = 2'b00,
    MD_WR    = 2'b01,
    MD_RD    = 2'b10,
    MD_WR_RD = 2'b11
  } seq_mode_t;

endpackage

// File: rtl/seq_next_state.sv
module seq_next_state
  import capture_seq_pkg::*;
(
  input  seq_state_t cur_i,
  input  seq_mode_t  mode_q_i,
  input  logic       calib_done_i,
  input  logic       in_fifo_empty_i,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_mode_i,
  input  logic       wr_done_i,
  input  logic       rd_done_i,
  input  logic       dly_last_i,
  output seq_state_t nxt_o,
  output logic       acc_wr_o,
  output logic       acc_rd_o
);

  always_comb begin
    nxt_o    = cur_i;
    acc_wr_o = 1'b0;
    acc_rd_o = 1'b0;
    case (cur_i)
      ST_IDLE: begin
        if (calib_done_i && in_fifo_empty_i) nxt_o = ST_CMD;
      end
      ST_CMD: begin
        if (cmd_valid_i) begin
          case (seq_mode_t'(cmd_mode_i))
            MD_WR, MD_WR_RD: begin
              nxt_o    = ST_WRITE;
              acc_wr_o = 1'b1;
            end
            MD_RD: begin
              nxt_o    = ST_READ;
              acc_rd_o = 1'b1;
            end
            default: nxt_o = ST_CMD;
          endcase
        end
      end
      ST_WRITE: begin
        if (wr_done_i) nxt_o = (mode_q_i == MD_WR_RD) ? ST_DELAY : ST_CMD;
      end
      ST_DELAY: begin
        if (dly_last_i) nxt_o = ST_READ;
      end
      ST_READ: begin
        if (rd_done_i) nxt_o = ST_CMD;
      end
      default: nxt_o = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/seq_delay_timer.sv
module seq_delay_timer #(
  parameter int DELAY_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic in_delay_i,
  output logic dly_last_o
);

  localparam int CNT_W = (DELAY_CYC > 1) ? $clog2(DELAY_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !in_delay_i) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign dly_last_o = in_delay_i && (cnt_q == LAST);

  // R9: outside the pause the count is back at zero one edge later
  assert_cnt_clear_R9: assert property (@(posedge clk) disable iff (rst)
    !in_delay_i |=> (cnt_q == '0));

endmodule

// File: rtl/seq_out_reg.sv
module seq_out_reg
  import capture_seq_pkg::*;
#(
  parameter int PARAM_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  seq_state_t         cur_i,
  input  seq_state_t         nxt_i,
  input  logic               acc_wr_i,
  input  logic               acc_rd_i,
  input  logic               cmd_valid_i,
  input  logic [1:0]         cmd_mode_i,
  input  logic [PARAM_W-1:0] cmd_param_i,
  output logic               wr_en_o,
  output logic               rd_en_o,
  output logic               cmd_ready_o,
  output logic               init_o,
  output logic               wr_load_o,
  output logic               rd_load_o,
  output seq_mode_t          mode_q_o,
  output logic [PARAM_W-1:0] cfg_param_o
);

  logic accept;
  assign accept = acc_wr_i || acc_rd_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en_o     <= 1'b0;
      rd_en_o     <= 1'b0;
      cmd_ready_o <= 1'b0;
      init_o      <= 1'b1;
      wr_load_o   <= 1'b0;
      rd_load_o   <= 1'b0;
      mode_q_o    <= MD_NONE;
      cfg_param_o <= '0;
    end else begin
      wr_en_o     <= (nxt_i == ST_WRITE);
      rd_en_o     <= (nxt_i == ST_READ);
      cmd_ready_o <= (nxt_i == ST_CMD);
      init_o      <= (nxt_i == ST_IDLE);
      wr_load_o   <= acc_wr_i;
      rd_load_o   <= acc_rd_i || ((cur_i == ST_WRITE) && (nxt_i == ST_DELAY));
      if (accept) begin
        mode_q_o    <= seq_mode_t'(cmd_mode_i);
        cfg_param_o <= cmd_param_i;
      end else if (nxt_i == ST_IDLE) begin
        mode_q_o    <= MD_NONE;
        cfg_param_o <= '0;
      end
    end
  end

  // R3: no write-parameter strobe unless the previous state was CMD
  assert_wload_only_cmd_R3: assert property (@(posedge clk) disable iff (rst)
    (cur_i != ST_CMD) |=> !wr_load_o);

  // R3: the parameter register holds outside the command window
  assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (cur_i != ST_CMD && nxt_i != ST_IDLE) |=> $stable(cfg_param_o));

  // R6: the unused mode code leaves parameters and strobes untouched
  assert_undef_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (cur_i == ST_CMD && cmd_valid_i && cmd_mode_i == 2'b00)
      |=> ($stable(cfg_param_o) && !wr_load_o && !rd_load_o));

endmodule

// File: rtl/capture_seq_ctrl.sv
module capture_seq_ctrl
  import capture_seq_pkg::*;
#(
  parameter int PARAM_W   = 16,
  parameter int DELAY_CYC = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               calib_done_i,
  input  logic               in_fifo_empty_i,
  input  logic               cmd_valid_i,
  input  logic [1:0]         cmd_mode_i,
  input  logic [PARAM_W-1:0] cmd_param_i,
  input  logic               wr_done_i,
  input  logic               rd_done_i,
  output logic [2:0]         state_o,
  output logic               wr_en_o,
  output logic               rd_en_o,
  output logic               cmd_ready_o,
  output logic               init_o,
  output logic               wr_load_o,
  output logic               rd_load_o,
  output logic [PARAM_W-1:0] cfg_param_o
);

  seq_state_t state_q;
  seq_state_t state_d;
  seq_mode_t  mode_q;
  logic       acc_wr;
  logic       acc_rd;
  logic       dly_last;

  seq_next_state u_next (
    .cur_i           (state_q),
    .mode_q_i        (mode_q),
    .calib_done_i    (calib_done_i),
    .in_fifo_empty_i (in_fifo_empty_i),
    .cmd_valid_i     (cmd_valid_i),
    .cmd_mode_i      (cmd_mode_i),
    .wr_done_i       (wr_done_i),
    .rd_done_i       (rd_done_i),
    .dly_last_i      (dly_last),
    .nxt_o           (state_d),
    .acc_wr_o        (acc_wr),
    .acc_rd_o        (acc_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  seq_delay_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .in_delay_i (state_q == ST_DELAY),
    .dly_last_o (dly_last)
  );

  seq_out_reg #(.PARAM_W(PARAM_W)) u_out (
    .clk         (clk),
    .rst         (rst),
    .cur_i       (state_q),
    .nxt_i       (state_d),
    .acc_wr_i    (acc_wr),
    .acc_rd_i    (acc_rd),
    .cmd_valid_i (cmd_valid_i),
    .cmd_mode_i  (cmd_mode_i),
    .cmd_param_i (cmd_param_i),
    .wr_en_o     (wr_en_o),
    .rd_en_o     (rd_en_o),
    .cmd_ready_o (cmd_ready_o),
    .init_o      (init_o),
    .wr_load_o   (wr_load_o),
    .rd_load_o   (rd_load_o),
    .mode_q_o    (mode_q),
    .cfg_param_o (cfg_param_o)
  );

  assign state_o = state_q;

  // R1: reset always lands in IDLE
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (state_q == ST_IDLE && init_o));

  // R2: IDLE is held until calibration and an empty input FIFO
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !(calib_done_i && in_fifo_empty_i)) |=> (state_q == ST_IDLE));

  // R7: write-only completion returns to the command window
  assert_wr_only_exit_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WRITE && wr_done_i && mode_q == MD_WR) |=> (state_q == ST_CMD));

  // R8: write-then-read completion enters DELAY with a read-parameter strobe
  assert_wr_rd_delay_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WRITE && wr_done_i && mode_q == MD_WR_RD)
      |=> (state_q == ST_DELAY && rd_load_o));

  // R9: DELAY only leaves for READ, and does so when the timer expires
  assert_delay_exit_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DELAY) |=> (state_q == ST_DELAY || state_q == ST_READ));
  assert_delay_done_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DELAY && dly_last) |=> (state_q == ST_READ));

  // R10: read completion returns to the command window
  assert_rd_exit_R10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_READ && rd_done_i) |=> (state_q == ST_CMD));

  // R11: enables track the state register and never overlap
  assert_enables_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o == (state_q == ST_WRITE)) && (rd_en_o == (state_q == ST_READ)) &&
    (cmd_ready_o == (state_q == ST_CMD)) && (init_o == (state_q == ST_IDLE)));
  assert_enables_excl_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_en_o, rd_en_o, cmd_ready_o, init_o}));

  // R12: a done input from the wrong phase does not move the machine out of CMD
  assert_stray_done_R12: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CMD && !cmd_valid_i) |=> (state_q == ST_CMD));

endmodule

// File: tb/tb_capture_seq_ctrl.sv
`timescale 1ns/1ps
module tb_capture_seq_ctrl;

  localparam int PW = 8;
  localparam int DC = 4;
  localparam int NV = 19;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          calib = 1'b0, empty = 1'b0, vld = 1'b0, wd = 1'b0, rdn = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic [PW-1:0] param = 8'hA5;
  logic [2:0]    state;
  logic          wr_en, rd_en, cmd_rdy, init, wld, rld;
  logic [PW-1:0] cfg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  capture_seq_ctrl #(.PARAM_W(PW), .DELAY_CYC(DC)) dut (
    .clk(clk), .rst(rst), .calib_done_i(calib), .in_fifo_empty_i(empty),
    .cmd_valid_i(vld), .cmd_mode_i(mode), .cmd_param_i(param),
    .wr_done_i(wd), .rd_done_i(rdn), .state_o(state), .wr_en_o(wr_en),
    .rd_en_o(rd_en), .cmd_ready_o(cmd_rdy), .init_o(init),
    .wr_load_o(wld), .rd_load_o(rld), .cfg_param_o(cfg)
  );

  // {calib, empty, valid, mode[1:0], wr_done, rd_done, exp_state[2:0], exp_wload, exp_rload}
  localparam logic [11:0] VEC [NV] = '{
    {1'b0,1'b1,1'b0,2'b00,1'b0,1'b0,3'd0,1'b0,1'b0}, // 0  R2 no calib
    {1'b1,1'b0,1'b0,2'b00,1'b0,1'b0,3'd0,1'b0,1'b0}, // 1  R2 fifo not empty
    {1'b1,1'b1,1'b1,2'b01,1'b0,1'b0,3'd1,1'b0,1'b0}, // 2  R2 go, R3 cmd ignored in IDLE
    {1'b1,1'b1,1'b1,2'b00,1'b0,1'b0,3'd1,1'b0,1'b0}, // 3  R6 unused code
    {1'b1,1'b1,1'b0,2'b00,1'b1,1'b1,3'd1,1'b0,1'b0}, // 4  R12 stray done in CMD
    {1'b1,1'b1,1'b1,2'b01,1'b0,1'b0,3'd2,1'b1,1'b0}, // 5  R4 write-only
    {1'b1,1'b1,1'b1,2'b10,1'b0,1'b0,3'd2,1'b0,1'b0}, // 6  R3 cmd in WRITE
    {1'b1,1'b1,1'b0,2'b00,1'b0,1'b1,3'd2,1'b0,1'b0}, // 7  R12 rd_done in WRITE
    {1'b1,1'b1,1'b0,2'b00,1'b1,1'b0,3'd1,1'b0,1'b0}, // 8  R7
    {1'b1,1'b1,1'b1,2'b10,1'b0,1'b0,3'd3,1'b0,1'b1}, // 9  R5
    {1'b1,1'b1,1'b0,2'b00,1'b1,1'b0,3'd3,1'b0,1'b0}, // 10 R12 wr_done in READ
    {1'b1,1'b1,1'b0,2'b00,1'b0,1'b1,3'd1,1'b0,1'b0}, // 11 R10
    {1'b1,1'b1,1'b1,2'b11,1'b0,1'b0,3'd2,1'b1,1'b0}, // 12 R4 write-then-read
    {1'b1,1'b1,1'b0,2'b00,1'b1,1'b0,3'd4,1'b0,1'b1}, // 13 R8
    {1'b1,1'b1,1'b0,2'b00,1'b0,1'b0,3'd4,1'b0,1'b0}, // 14 R9
    {1'b1,1'b1,1'b0,2'b00,1'b0,1'b1,3'd4,1'b0,1'b0}, // 15 R9, R12 rd_done in DELAY
    {1'b1,1'b1,1'b0,2'b00,1'b0,1'b0,3'd4,1'b0,1'b0}, // 16 R9
    {1'b1,1'b1,1'b0,2'b00,1'b0,1'b0,3'd3,1'b0,1'b0}, // 17 R9 READ after DC cycles
    {1'b1,1'b1,1'b0,2'b00,1'b0,1'b1,3'd1,1'b0,1'b0}  // 18 R10
  };

  function automatic string tag_of(int i);
    case (i)
      0, 1, 2: return "R2";
      3:       return "R6";
      4, 7, 10, 15: return "R12";
      5, 12:   return "R4";
      6:       return "R3";
      8:       return "R7";
      9:       return "R5";
      13:      return "R8";
      14, 16, 17: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_enables(string req, int st);
    chk(req, "state", state, st);
    chk("R11", "wr_en", wr_en, st == 2);
    chk("R11", "rd_en", rd_en, st == 3);
    chk("R11", "cmd_ready", cmd_rdy, st == 1);
    chk("R11", "init", init, st == 0);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    step();
    // R1 reset state
    chk_enables("R1", 0);
    chk("R1", "wr_load", wld, 0);
    chk("R1", "rd_load", rld, 0);
    chk("R1", "cfg_param", cfg, 0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {calib, empty, vld, mode, wd, rdn} = VEC[i][11:5];
      step();
      chk_enables(tag_of(i), int'(VEC[i][4:2]));
      chk(tag_of(i), "wr_load", wld, int'(VEC[i][1]));
      chk(tag_of(i), "rd_load", rld, int'(VEC[i][0]));
    end
    chk("R4", "cfg_param after table", cfg, 8'hA5);

    // R6: unused code with a new parameter leaves the parameter register
    @(negedge clk);
    {vld, mode, wd, rdn} = {1'b1, 2'b00, 1'b0, 1'b0};
    param = 8'h5A;
    step();
    chk("R6", "state", state, 1);
    chk("R6", "cfg_param", cfg, 8'hA5);

    // R4: write-only command latches its parameter
    @(negedge clk);
    mode = 2'b01;
    param = 8'h3C;
    step();
    chk("R4", "state", state, 2);
    chk("R4", "cfg_param", cfg, 8'h3C);

    // R3: command during WRITE is not taken
    @(negedge clk);
    mode = 2'b10;
    param = 8'h77;
    step();
    chk("R3", "state", state, 2);
    chk("R3", "cfg_param", cfg, 8'h3C);
    chk("R3", "wr_load", wld, 0);

    // R1: reset in the middle of WRITE
    @(negedge clk);
    vld = 1'b0;
    rst = 1'b1;
    step();
    chk_enables("R1", 0);
    chk("R1", "cfg_param", cfg, 0);
    @(negedge clk);
    rst = 1'b0;
    calib = 1'b0;
    step();
    chk("R2", "state held without calib", state, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule